// File: doc/BRIEF.md
# Runtime-Selectable CPU Clock Generator

This block turns a single oscillator input (nominally 32 MHz) into all of a small computer's clocks. A five-bit binary prescaler gives fixed half, quarter and eighth rate outputs (16, 8 and 4 MHz at the nominal input). A separate toggle divider gives a reference for the serial ports. The CPU clock is picked from eight sources: the five prescaler taps (16 MHz down to 1 MHz) and three slow test rates whose half periods are parameters (1 kHz, 8 Hz and 1 Hz by default).

The speed code comes from a three-bit switch input until software first writes to the speed port, an I/O write at low address byte 0xFF. The low three data bits of the first such write are latched, and from then on the latched code rules and the switches are ignored. A change of speed never produces a runt pulse. The output is parked low during a low phase of the old source. It stays low until the new source has a falling edge, and it then follows the new source. The bus cycle that requested the change therefore finishes at the old speed.

Top module: `cgen_cpu_clock`

## Requirements
- R1: The prescaler counts oscillator edges from reset. After n rising edges, clk_16, clk_8 and clk_4 equal bits 0, 1 and 2 of n, so clk_4 only rises while clk_8 and clk_16 are low.
- R2: clk_baud toggles every BAUD_HALF oscillator edges and starts low, so it is low when floor(n/BAUD_HALF) is even.
- R3: Speed code k for k = 0..4 selects prescaler bit k, which has a half period of 2^k edges. Codes 5, 6 and 7 select the slow sources, whose half periods are SLOW0_HALF, SLOW1_HALF and SLOW2_HALF. Every rate has equal high and low phases.
- R4: Until the speed port has been written, the speed code is sw_sel.
- R5: An I/O write is recognised when iorq_n = 0, wr_n = 0 and addr = 0xFF. In the first cycle of such a write, io_data_lo is latched as the speed code. From then on sw_sel has no effect.
- R6: A write with another address, or with only one of iorq_n and wr_n low, leaves the latched speed code unchanged.
- R7: A change of code takes effect only while the current source is low. The output then stays low until a falling edge of the new source, and it then follows the new source one oscillator edge late. No phase is shorter than the half period of the faster of the two rates.
- R8: During reset every clock output is low and the selected code is 0.
- R9: A write held for several cycles latches only the data of its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Master oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_sel | input | 3 | Speed code from switches |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | Low byte of the I/O address |
| io_data_lo | input | 3 | Low three bits of the data bus |
| clk_16 | output | 1 | Oscillator / 2 |
| clk_8 | output | 1 | Oscillator / 4 |
| clk_4 | output | 1 | Oscillator / 8 |
| clk_baud | output | 1 | Serial reference, oscillator / (2*BAUD_HALF) |
| cpu_clk | output | 1 | Selected CPU clock |

## Verification
The fixed outputs and the serial reference are due on the same oscillator edge that advances the prescaler. The latched code is due one edge after the first cycle of a port write. The CPU clock output repeats its source one edge late. A code change parks the output, and the handover to the new source follows on the edge after that source falls. A behavioural model in the bench steps through these same latencies on each rising edge, and every output is compared at the falling edge that follows. Period and duty measurements for each code are taken only after a settling time longer than the slowest source's worst-case handover.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 1 << SEL_W;
    localparam int NUM_BIN = 5;
    localparam int NUM_TOG = NUM_SRC - NUM_BIN;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic {
        SW_RUN  = 1'b0,
        SW_PARK = 1'b1
    } sw_state_e;

    typedef struct packed {
        sw_state_e          st;
        sel_t               cur;
        logic               out;
        logic [NUM_SRC-1:0] prev;
    } sw_regs_t;

    typedef struct packed {
        sel_t code;
        logic valid;
        logic hit_prev;
    } port_regs_t;
endpackage

// File: rtl/cgen_bin_div.sv
module cgen_bin_div #(
    parameter int W = 5
) (
    input  logic         clk_osc,
    input  logic         rst_n,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cgen_tog_div.sv
module cgen_tog_div #(
    parameter int unsigned HALF = 4
) (
    input  logic clk_osc,
    input  logic rst_n,
    output logic tog_o
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tog;
    } tog_regs_t;

    tog_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == LAST) begin
            r_d.cnt = '0;
            r_d.tog = ~r_q.tog;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tog_o = r_q.tog;
endmodule

// File: rtl/cgen_portreg.sv
module cgen_portreg
    import cgen_pkg::*;
#(
    parameter logic [7:0] PORT_ADDR = 8'hFF
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       iorq_n,
    input  logic       wr_n,
    input  logic [7:0] addr,
    input  sel_t       io_data_lo,
    output sel_t       code_o,
    output logic       valid_o
);
    port_regs_t r_d, r_q;
    logic       hit;

    always_comb begin
        hit = !iorq_n && !wr_n && (addr == PORT_ADDR);
        r_d = r_q;
        r_d.hit_prev = hit;
        if (hit && !r_q.hit_prev) begin
            r_d.code  = io_data_lo;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign code_o  = r_q.code;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/cgen_swmux.sv
module cgen_swmux
    import cgen_pkg::*;
(
    input  logic               clk_osc,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  sel_t               target,
    output logic               clk_o,
    output sel_t               cur_o,
    output logic               park_o
);
    sw_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = src;
        r_d.out  = 1'b0;
        unique case (r_q.st)
            SW_RUN: begin
                if ((target != r_q.cur) && !src[r_q.cur]) begin
                    r_d.st  = SW_PARK;
                    r_d.cur = target;
                end else begin
                    r_d.out = src[r_q.cur];
                end
            end
            SW_PARK: begin
                if (r_q.prev[r_q.cur] && !src[r_q.cur]) begin
                    r_d.st = SW_RUN;
                end
            end
            default: r_d.st = SW_RUN;
        endcase
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= SW_RUN;
            r_q.cur  <= '0;
            r_q.out  <= 1'b0;
            r_q.prev <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_o  = r_q.out;
    assign cur_o  = r_q.cur;
    assign park_o = (r_q.st == SW_PARK);
endmodule

// File: rtl/cgen_cpu_clock.sv
module cgen_cpu_clock
    import cgen_pkg::*;
#(
    parameter int unsigned SLOW0_HALF = 16000,
    parameter int unsigned SLOW1_HALF = 2000000,
    parameter int unsigned SLOW2_HALF = 16000000,
    parameter int unsigned BAUD_HALF  = 13,
    parameter logic [7:0]  PORT_ADDR  = 8'hFF
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic [2:0] sw_sel,
    input  logic       iorq_n,
    input  logic       wr_n,
    input  logic [7:0] addr,
    input  logic [2:0] io_data_lo,
    output logic       clk_16,
    output logic       clk_8,
    output logic       clk_4,
    output logic       clk_baud,
    output logic       cpu_clk
);
    localparam int unsigned TOG_HALF [NUM_TOG] = '{SLOW0_HALF, SLOW1_HALF, SLOW2_HALF};

    logic [NUM_BIN-1:0] bin_cnt;
    logic [NUM_SRC-1:0] src;
    sel_t               port_code;
    logic               port_valid;
    sel_t               target;
    sel_t               cur_sel;
    logic               parked;

    cgen_bin_div #(.W(NUM_BIN)) u_bin (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .cnt_o   (bin_cnt)
    );

    assign src[NUM_BIN-1:0] = bin_cnt;

    for (genvar g = 0; g < NUM_TOG; g++) begin : g_slow
        cgen_tog_div #(.HALF(TOG_HALF[g])) u_slow (
            .clk_osc (clk_osc),
            .rst_n   (rst_n),
            .tog_o   (src[NUM_BIN+g])
        );
    end

    cgen_tog_div #(.HALF(BAUD_HALF)) u_baud (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .tog_o   (clk_baud)
    );

    cgen_portreg #(.PORT_ADDR(PORT_ADDR)) u_port (
        .clk_osc    (clk_osc),
        .rst_n      (rst_n),
        .iorq_n     (iorq_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .io_data_lo (io_data_lo),
        .code_o     (port_code),
        .valid_o    (port_valid)
    );

    assign target = port_valid ? port_code : sw_sel;

    cgen_swmux u_sw (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .src     (src),
        .target  (target),
        .clk_o   (cpu_clk),
        .cur_o   (cur_sel),
        .park_o  (parked)
    );

    assign clk_16 = bin_cnt[0];
    assign clk_8  = bin_cnt[1];
    assign clk_4  = bin_cnt[2];
endmodule

// File: rtl/cgen_cpu_clock_chk.sv
module cgen_cpu_clock_chk #(
    parameter logic [7:0] PORT_ADDR = 8'hFF
) (
    input logic       clk_osc,
    input logic       rst_n,
    input logic       clk_16,
    input logic       clk_8,
    input logic       clk_4,
    input logic       cpu_clk,
    input logic [2:0] cur_sel,
    input logic       parked,
    input logic [2:0] port_code,
    input logic       port_valid,
    input logic       iorq_n,
    input logic       wr_n,
    input logic [7:0] addr,
    input logic [2:0] io_data_lo
);
    logic hit;
    assign hit = !iorq_n && !wr_n && (addr == PORT_ADDR);

    AST_CLK4_ALIGNED: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $rose(clk_4) |-> (!clk_8 && !clk_16)); // R1

    AST_SWITCH_WHILE_LOW: assert property (@(posedge clk_osc) disable iff (!rst_n)
        $changed(cur_sel) |-> !cpu_clk); // R7

    AST_PARKED_LOW: assert property (@(posedge clk_osc) disable iff (!rst_n)
        parked |-> !cpu_clk); // R7

    AST_PORT_LATCH: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (hit && !$past(hit)) |=> (port_valid && port_code == $past(io_data_lo))); // R5

    AST_PORT_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!hit || $past(hit)) |=> $stable(port_code)); // R6

    AST_VALID_STICKY: assert property (@(posedge clk_osc) disable iff (!rst_n)
        port_valid |=> port_valid); // R5
endmodule

bind cgen_cpu_clock cgen_cpu_clock_chk #(.PORT_ADDR(PORT_ADDR)) chk_i (
    .clk_osc    (clk_osc),
    .rst_n      (rst_n),
    .clk_16     (clk_16),
    .clk_8      (clk_8),
    .clk_4      (clk_4),
    .cpu_clk    (cpu_clk),
    .cur_sel    (cur_sel),
    .parked     (parked),
    .port_code  (port_code),
    .port_valid (port_valid),
    .iorq_n     (iorq_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .io_data_lo (io_data_lo)
);

// File: tb/cgen_cpu_clock_tb_top.sv
module cgen_cpu_clock_tb_top;
    localparam int H5 = 20;
    localparam int H6 = 36;
    localparam int H7 = 50;
    localparam int HB = 3;
    localparam int SETTLE = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sw_sel = 3'd0;
    logic       iorq_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [2:0] io_data_lo = 3'd0;
    logic       clk_16, clk_8, clk_4, clk_baud, cpu_clk;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    cgen_cpu_clock #(
        .SLOW0_HALF(H5), .SLOW1_HALF(H6), .SLOW2_HALF(H7),
        .BAUD_HALF(HB), .PORT_ADDR(8'hFF)
    ) dut_i (
        .clk_osc(clk), .rst_n(rst_n), .sw_sel(sw_sel), .iorq_n(iorq_n),
        .wr_n(wr_n), .addr(addr), .io_data_lo(io_data_lo),
        .clk_16(clk_16), .clk_8(clk_8), .clk_4(clk_4),
        .clk_baud(clk_baud), .cpu_clk(cpu_clk)
    );

    function automatic int half_of(int k);
        if (k < 5) return 1 << k;
        if (k == 5) return H5;
        if (k == 6) return H6;
        return H7;
    endfunction

    function automatic bit src_at(int k, longint c);
        return bit'((c / half_of(k)) % 2);
    endfunction

    task automatic check(bit ok, string req, int got, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on each rising edge
    longint   n = 0;
    int       m_cur = 0, m_last = 0;
    bit       m_park = 0, m_out = 0, m_valid = 0, m_hitp = 0;
    int       m_code = 0;
    bit [7:0] m_prev = '0;
    bit [7:0] s_v;
    int       tgt_v;
    bit       hit_v;

    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; m_cur = 0; m_last = 0; m_park = 0; m_out = 0;
            m_valid = 0; m_hitp = 0; m_code = 0; m_prev = '0;
        end else begin
            for (int k = 0; k < 8; k++) s_v[k] = src_at(k, n);
            tgt_v = m_valid ? m_code : int'(sw_sel);
            if (!m_park) begin
                if (tgt_v != m_cur && !s_v[m_cur]) begin
                    m_last = m_cur; m_cur = tgt_v; m_park = 1; m_out = 0;
                end else m_out = s_v[m_cur];
            end else begin
                if (m_prev[m_cur] && !s_v[m_cur]) m_park = 0;
                m_out = 0;
            end
            m_prev = s_v;
            hit_v = !iorq_n && !wr_n && addr == 8'hFF;
            if (hit_v && !m_hitp) begin m_code = int'(io_data_lo); m_valid = 1; end
            m_hitp = hit_v;
            n++;
        end
    end

    // Per-cycle comparison and phase-length monitor at the falling edge
    bit cpu_p = 0;
    int plen = 0;
    bit seen_edge = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            check(!clk_16 && !clk_8 && !clk_4 && !clk_baud && !cpu_clk,
                  "R8 outputs low in reset", {clk_16, clk_8, clk_4, clk_baud, cpu_clk}, 0);
            cpu_p = 0; plen = 0; seen_edge = 0;
        end else begin
            check(clk_16 == n[0], "R1 clk_16", clk_16, int'(n[0]));
            check(clk_8  == n[1], "R1 clk_8",  clk_8,  int'(n[1]));
            check(clk_4  == n[2], "R1 clk_4",  clk_4,  int'(n[2]));
            check(clk_baud == bit'((n / HB) % 2), "R2 clk_baud", clk_baud, int'((n / HB) % 2));
            check(cpu_clk == m_out, "R7 cpu_clk vs model", cpu_clk, m_out);
            if (cpu_clk != cpu_p) begin
                if (seen_edge) begin
                    int lim;
                    lim = (half_of(m_last) < half_of(m_cur)) ? half_of(m_last) : half_of(m_cur);
                    check(plen >= lim, "R7 minimum phase", plen, lim);
                end
                seen_edge = 1; plen = 1;
            end else plen++;
            cpu_p = cpu_clk;
        end
    end

    task automatic measure(int exp_half, string req);
        bit p;
        int per, hi;
        repeat (SETTLE) @(negedge clk);
        p = cpu_clk;
        forever begin @(negedge clk); if (!p && cpu_clk) break; p = cpu_clk; end
        per = 0; hi = 0; p = cpu_clk;
        forever begin
            if (cpu_clk) hi++;
            per++;
            @(negedge clk);
            if (!p && cpu_clk) break;
            p = cpu_clk;
        end
        check(per == 2 * exp_half, req, per, 2 * exp_half);
        check(hi == exp_half, {req, " duty R3"}, hi, exp_half);
    endtask

    task automatic io_write(logic [7:0] a, logic [2:0] d, bit use_iorq, bit use_wr);
        @(negedge clk);
        addr = a; io_data_lo = d;
        iorq_n = !use_iorq; wr_n = !use_wr;
        @(negedge clk);
        io_data_lo = ~d;          // R9: later data of a held write must be ignored
        repeat (2) @(negedge clk);
        iorq_n = 1; wr_n = 1; addr = 8'h00;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            sw_sel = 3'(c);
            measure(half_of(c), $sformatf("R4 R3 switch code %0d period", c));
        end
        sw_sel = 3'd2;
        measure(half_of(2), "R4 back to code 2");
        io_write(8'hFF, 3'd6, 1, 1);
        sw_sel = 3'd1;
        measure(H6, "R5 R9 port code 6, switches ignored");
        io_write(8'hFE, 3'd2, 1, 1);
        measure(H6, "R6 other address ignored");
        io_write(8'hFF, 3'd2, 1, 0);
        measure(H6, "R6 iorq only ignored");
        io_write(8'hFF, 3'd2, 0, 1);
        measure(H6, "R6 wr only ignored");
        io_write(8'hFF, 3'd0, 1, 1);
        measure(1, "R5 port code 0");
        io_write(8'hFF, 3'd4, 1, 1);
        measure(16, "R5 port code 4");
        io_write(8'hFF, 3'd7, 1, 1);
        sw_sel = 3'd3;
        measure(H7, "R5 port code 7");
        io_write(8'hFF, 3'd3, 1, 1);
        measure(8, "R7 slow to fast");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule